// File: doc/BRIEF.md
# Register File with Zero and Link Registers

This block holds the general-purpose operand registers of a processor core. It has thirty-two 32-bit entries. Two read ports are purely combinational and serve the two source operands. One write port stores a result on the rising clock edge.

Two entries behave specially. Entry 0 is a constant zero: a write to it is accepted but has no effect. Entry 31 is the return-address register. A separate link input loads it directly, with no destination index, so a call instruction can save its return address while the general port writes a different register in the same cycle.

The block is built from four modules:
- a write decoder that turns the index, enable and link inputs into per-entry load strobes;
- a storage array of enabled registers with asynchronous reset;
- one read multiplexer per read port;
- the top module that wires these together.

Top module: `regfile_zl`

## Requirements
- R1: While `rst_n` is low, and after it rises, every entry reads as zero until it is written.
- R2: A read port returns the stored value of the entry named by its index in the same cycle, without a clock edge.
- R3: Reading index 0 on either port always returns zero.
- R4: A write with `wr_en` high and `wr_idx` equal to 0 leaves entry 0 reading as zero.
- R5: When `wr_en` is high, entry `wr_idx` takes `wr_data` at the rising clock edge. When `wr_en` is low, no entry changes through the general port.
- R6: When `link_en` is high, entry 31 takes `link_data` at the rising clock edge, whatever `wr_idx` holds.
- R7: When `link_en` is high and the general port also writes entry 31 in the same cycle, entry 31 takes `link_data`.
- R8: When `link_en` is high and the general port writes an entry other than 31 in the same cycle, both writes take effect.
- R9: A read of an entry in the cycle it is being written returns the value it held before that edge.
- R10: The two read ports are independent. When both name the same index, they return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, clears all entries |
| rd_idx_a | input | 5 | Index for read port A |
| rd_data_a | output | 32 | Data from read port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_b | output | 32 | Data from read port B |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 5 | General write destination index |
| wr_data | input | 32 | General write data |
| link_en | input | 1 | Return-address write enable for entry 31 |
| link_data | input | 32 | Return-address value |

## Verification
A behavioural reference model is compared against both read ports on every clock. The stimulus includes:
- a sweep that writes a distinct pattern to every entry, which separates a wrong index decode from a stuck or aliased entry;
- a write to entry 0, which shows whether the zero mask is applied on the read path;
- reads of the entry being written in that cycle, which separate old-value reads from a bypass;
- cycles with the enable low but live data, which expose a missing enable;
- the link input alone, together with a general write to entry 31, and together with a write to another entry, which tell the priority rule apart from a merge or a lost write.

A second reset in mid-run confirms that every entry clears.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int NUM_REGS = 32;
    parameter int DATA_W   = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int LINK_IDX = NUM_REGS - 1;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
    import rf_pkg::*;
(
    input  logic                   wr_en,
    input  idx_t                   wr_idx,
    input  word_t                  wr_data,
    input  logic                   link_en,
    input  word_t                  link_data,
    output logic [NUM_REGS-1:0]    load,
    output word_t [NUM_REGS-1:0]   load_data
);
    // Entry 0 never loads; the link path wins on the link entry.
    assign load[0]      = 1'b0;
    assign load_data[0] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_dec
        logic gen_hit;
        assign gen_hit = wr_en && (wr_idx == IDX_W'(i));
        if (i == LINK_IDX) begin : g_link
            assign load[i]      = link_en || gen_hit;
            assign load_data[i] = link_en ? link_data : wr_data;
        end else begin : g_plain
            assign load[i]      = gen_hit;
            assign load_data[i] = wr_data;
        end
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import rf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_REGS-1:0]    load,
    input  word_t [NUM_REGS-1:0]   load_data,
    output word_t [NUM_REGS-1:0]   regs
);
    // Entry 0 has no flop behind it.
    assign regs[0] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_ent
        word_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (load[i]) begin
                q <= load_data[i];
            end
        end
        assign regs[i] = q;
    end

    logic unused_load0;
    assign unused_load0 = load[0] ^ (^load_data[0]);
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
(
    input  word_t [NUM_REGS-1:0]   regs,
    input  idx_t                   idx,
    output word_t                  data
);
    always_comb begin
        if (idx == '0) begin
            data = '0;
        end else begin
            data = regs[idx];
        end
    end
endmodule

// File: rtl/regfile_zl.sv
module regfile_zl
    import rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  rd_idx_a,
    output logic [31:0] rd_data_a,
    input  logic [4:0]  rd_idx_b,
    output logic [31:0] rd_data_b,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        link_en,
    input  logic [31:0] link_data
);
    logic [NUM_REGS-1:0]  load;
    word_t [NUM_REGS-1:0] load_data;
    word_t [NUM_REGS-1:0] regs;

    rf_write_decode u_dec (
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .link_en   (link_en),
        .link_data (link_data),
        .load      (load),
        .load_data (load_data)
    );

    rf_storage u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .regs      (regs)
    );

    rf_read_port u_rd_a (
        .regs (regs),
        .idx  (rd_idx_a),
        .data (rd_data_a)
    );

    rf_read_port u_rd_b (
        .regs (regs),
        .idx  (rd_idx_b),
        .data (rd_data_b)
    );
endmodule

// File: rtl/regfile_zl_checker.sv
module regfile_zl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  rd_idx_a,
    input logic [31:0] rd_data_a,
    input logic [4:0]  rd_idx_b,
    input logic [31:0] rd_data_b,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        link_en,
    input logic [31:0] link_data
);
    // R1: the first cycle out of reset sees cleared entries
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data_a == 32'd0 && rd_data_b == 32'd0));

    // R3: index 0 reads as zero
    a_r3_zero_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == 5'd0) |-> (rd_data_a == 32'd0));
    a_r3_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_b == 5'd0) |-> (rd_data_b == 32'd0));

    // R5: a general write lands unless the link path overrides it
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != 5'd0 && !(link_en && wr_idx == 5'd31))
        |=> ((rd_idx_a != $past(wr_idx)) || (rd_data_a == $past(wr_data))));

    // R7: the link write wins on entry 31
    a_r7_link_priority: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> ((rd_idx_b != 5'd31) || (rd_data_b == $past(link_data))));

    // R10: both ports agree on a common index
    a_r10_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));
endmodule

bind regfile_zl regfile_zl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx_a  (rd_idx_a),
    .rd_data_a (rd_data_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .link_en   (link_en),
    .link_data (link_data)
);

// File: tb/tb_regfile_zl.sv
module tb_regfile_zl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
    logic [31:0] wr_data = '0, link_data = '0;
    logic        wr_en = 1'b0, link_en = 1'b0;
    logic [31:0] rd_data_a, rd_data_b;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] model [32];

    always #10 clk = ~clk;

    regfile_zl dut (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .link_en(link_en), .link_data(link_data)
    );

    function automatic logic [31:0] expect_rd(input logic [4:0] idx);
        return (idx == 5'd0) ? 32'd0 : model[idx];
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock: drive at negedge, compare before the edge, update model after it.
    task automatic cyc(input logic we, input logic [4:0] widx, input logic [31:0] wdat,
                       input logic le, input logic [31:0] ldat,
                       input logic [4:0] ra, input logic [4:0] rb, input string tag);
        @(negedge clk);
        wr_en = we; wr_idx = widx; wr_data = wdat;
        link_en = le; link_data = ldat;
        rd_idx_a = ra; rd_idx_b = rb;
        #2;
        check({tag, " port A"}, rd_data_a, expect_rd(ra));
        check({tag, " port B"}, rd_data_b, expect_rd(rb));
        @(posedge clk);
        #1;
        if (rst_n) begin
            if (we && widx != 5'd0) model[widx] = wdat;
            if (le) model[31] = ldat;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0; link_en = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        #2;
        for (int i = 0; i < 32; i++) begin
            rd_idx_a = 5'(i); rd_idx_b = 5'(31 - i);
            #1;
            check("R1 during reset A", rd_data_a, 32'd0);
            check("R1 during reset B", rd_data_b, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        repeat (2) @(negedge clk);
        do_reset();
        // R1: after release, all entries read zero
        for (int i = 0; i < 32; i++) cyc(0, 0, 0, 0, 0, 5'(i), 5'(i), "R1 after reset");
        // R5/R9: fill every entry, reading the one being written (old value)
        for (int i = 0; i < 32; i++)
            cyc(1, 5'(i), 32'hA500_0000 + 32'(i * 32'h0101_0101), 0, 0, 5'(i), 5'((i + 1) % 32), "R9 read during write");
        // R4/R3: write entry 0 then read it
        cyc(1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, "R4 write to zero entry");
        cyc(0, 0, 0, 0, 0, 0, 5'd1, "R3 zero read");
        // R2/R10: read back with independent ports
        for (int i = 0; i < 32; i++) cyc(0, 0, 0, 0, 0, 5'(i), 5'(31 - i), "R2 R10 readback");
        // R5: enable low with live data changes nothing
        for (int i = 1; i < 32; i += 5) cyc(0, 5'(i), 32'hFFFF_FFFF, 0, 0, 5'(i), 5'(i), "R5 enable low");
        for (int i = 1; i < 32; i += 5) cyc(0, 0, 0, 0, 0, 5'(i), 5'(i), "R5 no change");
        // R6: link alone, general index pointing elsewhere but disabled
        cyc(0, 5'd7, 32'h1111_1111, 1, 32'h0040_0010, 5'd31, 5'd7, "R6 link write");
        cyc(0, 0, 0, 0, 0, 5'd31, 5'd7, "R6 link landed");
        // R7: collision on entry 31
        cyc(1, 5'd31, 32'h2222_2222, 1, 32'h0040_0020, 5'd31, 5'd31, "R7 collision");
        cyc(0, 0, 0, 0, 0, 5'd31, 5'd0, "R7 link wins");
        check("R7 explicit", rd_data_a, 32'h0040_0020);
        // R8: link and general to another entry
        cyc(1, 5'd5, 32'h3333_3333, 1, 32'h0040_0030, 5'd5, 5'd31, "R8 dual write");
        cyc(0, 0, 0, 0, 0, 5'd5, 5'd31, "R8 both landed");
        check("R8 explicit general", rd_data_a, 32'h3333_3333);
        check("R8 explicit link", rd_data_b, 32'h0040_0030);
        // General write to entry 31 without link
        cyc(1, 5'd31, 32'h4444_4444, 0, 32'h9999_9999, 5'd31, 5'd31, "R5 write to 31");
        cyc(0, 0, 0, 0, 0, 5'd31, 5'd30, "R5 write to 31 landed");
        // R1: reset again in mid-run
        do_reset();
        for (int i = 0; i < 32; i++) cyc(0, 0, 0, 0, 0, 5'(i), 5'(31 - i), "R1 second reset");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule